// File: doc/BRIEF.md
# Overlay Window Line Fetch Address Generator

This block drives the memory reads for one overlay window. Software gives it a framebuffer base address, the buffer's full line width in pixels (padding included), the size of the visible rectangle, the x and y offsets of that rectangle inside the buffer, and a pixel format code. On each frame-start pulse, while the window is enabled, it walks the rectangle line by line. For every line it issues a series of burst requests, each an address and a word count, over a valid/ready handshake.

The format code sets the bytes per pixel and whether the window uses per-pixel alpha blending. The padded buffer width sets the line stride. The padded width also picks the burst size: narrow buffers use shorter bursts, because long bursts on small surfaces give unstable fetches. All configuration is captured at frame start and held for the whole frame.

Top module: `win_fetch_agen`

## Requirements
- R1: After reset, `req_valid` and `busy` are low, `blend_pix` is low and `burst_len` is 16.
- R2: Format code 0 (16-bit 5-6-5 colour) uses 2 bytes per pixel. Codes 1 to 4 (32-bit with an unused byte) and codes 5 to 8 (32-bit with alpha) use 4 bytes per pixel. Codes 9 to 15 behave exactly like code 8.
- R3: From the cycle after an accepted frame start, `blend_pix` is high for codes 5 to 15 and low for codes 0 to 4.
- R4: From the cycle after an accepted frame start, `burst_len` is 8 when `whole_w` is below 128 and 16 otherwise.
- R5: The first request of line k (counting from 0) has the byte address `buf_base + (off_y + k) * whole_w * bpp + off_x * bpp`.
- R6: A line needs ceil(`vis_w` * bpp / 4) bus words of 4 bytes each. These are requested as full bursts of `burst_len` words, followed by one shorter burst for any remainder. Within a line, each request's address is the previous address plus 4 times the previous length.
- R7: A request that is not accepted keeps its address and length unchanged in the next cycle, unless `win_en` falls or a new frame start is applied.
- R8: `frame_start` has no effect while `win_en` is low. Deasserting `win_en` removes `req_valid` in the next cycle and stops the frame.
- R9: A frame start during a running frame restarts the fetch at the first request of line 0.
- R10: Changes to the configuration inputs after the frame start have no effect on the requests of that frame.
- R11: After the last request of the last line is accepted, `busy` and `req_valid` are low in the next cycle and stay low until the next frame start. A frame with `vis_w` or `vis_h` equal to zero issues no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_en | input | 1 | Window enable |
| frame_start | input | 1 | One-cycle pulse that starts a frame |
| buf_base | input | ADDR_W | Framebuffer base byte address |
| whole_w | input | DIM_W | Buffer line width in pixels, padding included |
| vis_w | input | DIM_W | Visible width in pixels |
| vis_h | input | DIM_W | Visible height in lines |
| off_x | input | DIM_W | Horizontal source offset in pixels |
| off_y | input | DIM_W | Vertical source offset in lines |
| pix_fmt | input | 4 | Pixel format code |
| req_ready | input | 1 | Memory side accepts the current request |
| req_valid | output | 1 | A burst request is presented |
| req_addr | output | ADDR_W | Burst start byte address |
| req_len | output | LEN_W | Burst length in bus words |
| burst_len | output | LEN_W | Maximum burst length for this frame |
| blend_pix | output | 1 | Per-pixel alpha blending selected |
| busy | output | 1 | A frame fetch is in progress |

## Verification
Some properties are checked by assertions on every cycle:
- No request has a zero length, and no request is longer than the frame's burst size.
- A stalled request holds steady.
- Requests stop one cycle after the enable falls.
- A request stream only begins after a frame start.

Other properties can only be shown by the bench's scenarios, which compare against values computed from the requirements:
- The arithmetic of the line start addresses, the stride and the remainder bursts.
- The format-to-size mapping and the narrow-buffer burst switch.
- The capture of configuration at frame start, the restart on a new frame start, and the empty-frame cases.

// File: rtl/win_fetch_agen.sv
module win_fetch_agen #(
  parameter int ADDR_W      = 32,
  parameter int DIM_W       = 12,
  parameter int BUS_BYTES   = 4,
  parameter int LONG_BURST  = 16,
  parameter int SHORT_BURST = 8,
  parameter int NARROW_PIX  = 128,
  parameter int LEN_W       = $clog2(LONG_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [DIM_W-1:0]  whole_w,
  input  logic [DIM_W-1:0]  vis_w,
  input  logic [DIM_W-1:0]  vis_h,
  input  logic [DIM_W-1:0]  off_x,
  input  logic [DIM_W-1:0]  off_y,
  input  logic [3:0]        pix_fmt,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [LEN_W-1:0]  burst_len,
  output logic              blend_pix,
  output logic              busy
);
  localparam int BSH  = $clog2(BUS_BYTES);
  localparam int LB_W = DIM_W + 3;

  logic [2:0]        bpp_in;
  logic [ADDR_W-1:0] stride_in, start_in;
  logic [LB_W-1:0]   bytes_in, words_in;

  assign bpp_in    = (pix_fmt == 4'd0) ? 3'd2 : 3'd4;
  assign stride_in = ADDR_W'(whole_w) * ADDR_W'(bpp_in);
  assign start_in  = buf_base + ADDR_W'(off_y) * stride_in + ADDR_W'(off_x) * ADDR_W'(bpp_in);
  assign bytes_in  = LB_W'(vis_w) * LB_W'(bpp_in);
  assign words_in  = (bytes_in + LB_W'(BUS_BYTES - 1)) >> BSH;

  logic              run;
  logic [ADDR_W-1:0] stride_q, line_q, cur_q;
  logic [LB_W-1:0]   words_q, line_words_q;
  logic [DIM_W-1:0]  lines_q;
  logic [LEN_W-1:0]  len;
  logic              fire;

  assign len       = (words_q > LB_W'(burst_len)) ? burst_len : words_q[LEN_W-1:0];
  assign fire      = run && req_ready;
  assign req_valid = run;
  assign req_addr  = cur_q;
  assign req_len   = len;
  assign busy      = run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run          <= 1'b0;
      stride_q     <= '0;
      line_q       <= '0;
      cur_q        <= '0;
      words_q      <= '0;
      line_words_q <= '0;
      lines_q      <= '0;
      burst_len    <= LEN_W'(LONG_BURST);
      blend_pix    <= 1'b0;
    end else if (!win_en) begin
      run <= 1'b0;
    end else if (frame_start) begin
      run          <= (vis_h != '0) && (words_in != '0);
      stride_q     <= stride_in;
      line_q       <= start_in;
      cur_q        <= start_in;
      words_q      <= words_in;
      line_words_q <= words_in;
      lines_q      <= vis_h;
      burst_len    <= (whole_w < DIM_W'(NARROW_PIX)) ? LEN_W'(SHORT_BURST) : LEN_W'(LONG_BURST);
      blend_pix    <= (pix_fmt > 4'd4);
    end else if (fire) begin
      if (words_q > LB_W'(len)) begin
        cur_q   <= cur_q + (ADDR_W'(len) << BSH);
        words_q <= words_q - LB_W'(len);
      end else if (lines_q == DIM_W'(1)) begin
        run <= 1'b0;
      end else begin
        line_q  <= line_q + stride_q;
        cur_q   <= line_q + stride_q;
        words_q <= line_words_q;
        lines_q <= lines_q - DIM_W'(1);
      end
    end
  end

  // R6
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= burst_len));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && win_en && !frame_start) |=>
      (req_valid && $stable(req_addr) && $stable(req_len)));

  // R8
  disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |=> !req_valid);

  // R8
  start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(frame_start && win_en));

endmodule

// File: tb/win_fetch_agen_test.sv
module win_fetch_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_en = 1'b0;
  logic        frame_start = 1'b0;
  logic [31:0] buf_base = '0;
  logic [11:0] whole_w = '0, vis_w = '0, vis_h = '0, off_x = '0, off_y = '0;
  logic [3:0]  pix_fmt = '0;
  logic        req_ready = 1'b0;
  logic        req_valid, blend_pix, busy;
  logic [31:0] req_addr;
  logic [4:0]  req_len, burst_len;

  int errs = 0, checks = 0, cyc = 0, rc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  win_fetch_agen uut (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .frame_start(frame_start),
    .buf_base(buf_base), .whole_w(whole_w), .vis_w(vis_w), .vis_h(vis_h),
    .off_x(off_x), .off_y(off_y), .pix_fmt(pix_fmt), .req_ready(req_ready),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .burst_len(burst_len), .blend_pix(blend_pix), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // waits for an accepted request; ready follows a pattern; checks R7 on stalls
  task automatic get_req(input int mode, output logic [31:0] a, output logic [4:0] l);
    logic [31:0] pa; logic [4:0] pl; bit stalled = 0;
    forever begin
      @(negedge clk);
      rc++;
      req_ready = (mode == 0) ? 1'b1 : ((rc % 3) != 1);
      if (stalled && req_valid) begin
        chk(req_addr == pa && req_len == pl, "R7 hold", req_addr, pa);
        stalled = 0;
      end
      if (req_valid && req_ready) begin a = req_addr; l = req_len; return; end
      if (req_valid) begin stalled = 1; pa = req_addr; pl = req_len; end
    end
  endtask

  task automatic start(input int base, input int ww, input int vw, input int vh,
                       input int ox, input int oy, input int fm);
    @(negedge clk);
    req_ready = 0;
    buf_base = base; whole_w = ww; vis_w = vw; vis_h = vh;
    off_x = ox; off_y = oy; pix_fmt = fm;
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    // R10: scramble configuration right after the capture
    buf_base = 32'hdead_0000; whole_w = 5; vis_w = 7; vis_h = 9;
    off_x = 3; off_y = 3; pix_fmt = ~fm[3:0];
  endtask

  task automatic frame(input int base, input int ww, input int vw, input int vh,
                       input int ox, input int oy, input int fm, input int mode);
    int bpp, words, bmax, stride;
    logic [31:0] a; logic [4:0] l;
    bpp    = (fm == 0) ? 2 : 4;
    stride = ww * bpp;
    words  = (vw * bpp + 3) / 4;
    bmax   = (ww < 128) ? 8 : 16;
    start(base, ww, vw, vh, ox, oy, fm);
    chk(blend_pix == (fm > 4), "R3 blend", blend_pix, fm > 4);
    chk(burst_len == bmax, "R4 burst", burst_len, bmax);
    for (int k = 0; k < vh; k++) begin
      int left, exp_a;
      left  = words;
      exp_a = base + (oy + k) * stride + ox * bpp;
      while (left > 0) begin
        int el;
        el = (left > bmax) ? bmax : left;
        get_req(mode, a, l);
        if (left == words) chk(a == exp_a, "R5 line addr", a, exp_a);
        else               chk(a == exp_a, "R6 burst addr", a, exp_a);
        chk(l == el, "R6 len (R2 size)", l, el);
        exp_a += el * 4;
        left  -= el;
      end
    end
    @(negedge clk);
    req_ready = 0;
    chk(!busy && !req_valid, "R11 idle after frame", busy, 0);
  endtask

  initial begin
    logic [31:0] a; logic [4:0] l;
    int ws[4] = '{64, 127, 128, 160};
    int vs[3] = '{1, 5, 33};
    repeat (3) @(negedge clk);
    chk(!req_valid && !busy, "R1 idle", req_valid, 0);
    chk(!blend_pix, "R1 blend", blend_pix, 0);
    chk(burst_len == 16, "R1 burst", burst_len, 16);
    rst_n = 1;

    // R8: frame start ignored while disabled
    start(32'h1000, 128, 8, 2, 0, 0, 1);
    repeat (4) begin
      @(negedge clk);
      chk(!req_valid && !busy, "R8 disabled start", req_valid, 0);
    end
    win_en = 1;

    // sweep over format, padded width, visible width (R2..R6, R10, R11)
    for (int fm = 0; fm < 10; fm++)
      for (int wi = 0; wi < 4; wi++)
        for (int vi = 0; vi < 3; vi++)
          frame(32'h4000_0000 + fm * 256, ws[wi], vs[vi], 2, vi + fm % 3, wi, fm, (fm + vi) % 2);
    frame(32'h0010_0000, 300, 130, 3, 17, 5, 12, 1);

    // R11: empty frames
    start(32'h2000, 128, 0, 4, 0, 0, 5);
    repeat (3) begin @(negedge clk); chk(!req_valid, "R11 zero width", req_valid, 0); end
    start(32'h2000, 128, 40, 0, 0, 0, 5);
    repeat (3) begin @(negedge clk); chk(!req_valid, "R11 zero height", req_valid, 0); end

    // R9: restart mid-frame
    start(32'h8000, 200, 100, 4, 2, 1, 3);
    get_req(0, a, l);
    @(negedge clk); req_ready = 0;
    start(32'h9000, 200, 100, 4, 2, 1, 3);
    get_req(0, a, l);
    chk(a == 32'h9000 + 200 * 4 + 8, "R9 restart addr", a, 32'h9000 + 808);

    // R8: dropping enable stops the frame
    @(negedge clk); req_ready = 0;
    chk(req_valid, "R8 running before drop", req_valid, 1);
    win_en = 0;
    @(negedge clk);
    chk(!req_valid && !busy, "R8 drop enable", req_valid, 0);
    win_en = 1;
    repeat (3) begin @(negedge clk); chk(!req_valid, "R8 stays stopped", req_valid, 0); end

    done = 1;
    summary();
  end
endmodule